// File: doc/BRIEF.md
# ADC Interrupt and FIFO Status Controller

This block turns ADC-side events into one level-sensitive interrupt request and keeps the status bits that tell software why the request was raised. It watches five inputs: the sample FIFO's not-empty, half-full and full flags, an end-of-scan pulse and an end-of-acquisition pulse. A 2-bit selector chooses one general source, and that source has its own enable. The end-of-acquisition event has a separate latch and a separate enable. The block also keeps a sticky overflow bit that records that the FIFO reached full.

Software programs the block through one write word, which carries the source select, the two enables and three write-1-to-clear strobes. A read word returns the three latched bits and a live copy of the not-empty flag. Each latched bit captures the rising edge of its source. The bit stays set until software writes a 1 to its clear strobe. The FIFO storage and the bus protocol are outside this block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all latched status bits are 0, both enables are 0, the source select is 00, and `irq_o` is 0.
- R2: Write bits [1:0] select the general source. 00 selects no source, 01 the end-of-scan pulse, 10 the FIFO half-full flag and 11 the FIFO not-empty flag. A rising edge of the selected source sets the general status bit (read bit 1) on the next clock edge. With select 00, no input sets this bit.
- R3: Write bit 2 is the general enable. `irq_o` reflects the general status bit only while this enable is 1.
- R4: A rising edge of the end-of-acquisition input sets read bit 0, whatever the enables are. Write bit 3 enables this bit onto `irq_o`.
- R5: In a write, bit 4 clears read bit 0, bit 5 clears read bit 1 and bit 6 clears read bit 2. A write with 0 in any of these bits leaves the matching status bit unchanged.
- R6: Clear strobes act only in the cycle of the write. An event that occurs after the write latches and stays set, even though software never writes a 0 to the strobe.
- R7: A rising edge of the FIFO full flag sets read bit 2. This bit stays 1 after the flag drops and is cleared only by its strobe.
- R8: Read bit 3 always equals the current FIFO not-empty input, with no register on the path.
- R9: When a set edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: `irq_o` is the OR of the enabled latched bits. It stays 1 until every enabled bit is cleared or disabled, and it never drops in a cycle without a write.
- R11: A source that stays high sets its bit only once. After that bit is cleared, the source does not set it again until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_nempty_i | input | 1 | FIFO holds at least one sample |
| fifo_half_i | input | 1 | FIFO is more than half occupied |
| fifo_full_i | input | 1 | FIFO is full |
| scan_done_i | input | 1 | End-of-channel-scan pulse |
| acq_done_i | input | 1 | End-of-acquisition pulse |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 7 | Control word: [1:0] select, [2] general enable, [3] acquisition enable, [6:4] clear strobes |
| rd_status_o | output | 4 | [0] acquisition, [1] general, [2] overflow, [3] live not-empty |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each latched bit is visible on `rd_status_o` one clock edge after its source rises. If an edge detector has the wrong state, the error appears in that cycle: either the bit sets a second time from a held level, or it fails to set at all. If a clear strobe sticks or a stored enable is wrong, the effect appears on `irq_o` in the cycle after the write, or when the next event should have latched but did not. The tests therefore sample each status bit and the request exactly one edge after every stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_SCAN   = 2'b01,
    SRC_HALF   = 2'b10,
    SRC_NEMPTY = 2'b11
  } gen_src_e;

  localparam int NUM_EV    = 5;
  localparam int EV_SCAN   = 0;
  localparam int EV_HALF   = 1;
  localparam int EV_NEMPTY = 2;
  localparam int EV_FULL   = 3;
  localparam int EV_ACQ    = 4;

  localparam int NUM_LATCH = 3;
  localparam int ST_ACQ    = 0;
  localparam int ST_GEN    = 1;
  localparam int ST_OVF    = 2;
  localparam int ST_LIVE   = 3;
  localparam int STAT_W    = NUM_LATCH + 1;

  localparam int SEL_W      = 2;
  localparam int CF_SEL_LSB = 0;
  localparam int CF_GEN_EN  = CF_SEL_LSB + SEL_W;
  localparam int CF_ACQ_EN  = CF_GEN_EN + 1;
  localparam int CF_CLR_LSB = CF_ACQ_EN + 1;
  localparam int CTRL_W     = CF_CLR_LSB + NUM_LATCH;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irq_src_mux.sv
module irq_src_mux
  import irq_pkg::*;
(
  input  gen_src_e          sel_i,
  input  logic [NUM_EV-1:0] rise_i,
  output logic              set_o
);
  always_comb begin
    unique case (sel_i)
      SRC_SCAN:   set_o = rise_i[EV_SCAN];
      SRC_HALF:   set_o = rise_i[EV_HALF];
      SRC_NEMPTY: set_o = rise_i[EV_NEMPTY];
      default:    set_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_stat_bit.sv
module irq_stat_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_o
);
  logic stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= set_i | (stat_q & ~clr_i);
  end

  assign stat_o = stat_q;

  // set has priority over a same-cycle clear
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stat_o);
  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !stat_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(stat_o));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_nempty_i,
  input  logic              fifo_half_i,
  input  logic              fifo_full_i,
  input  logic              scan_done_i,
  input  logic              acq_done_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] rd_status_o,
  output logic              irq_o
);
  gen_src_e             gen_sel_q;
  logic                 gen_en_q, acq_en_q;
  logic [NUM_EV-1:0]    ev_lvl, ev_rise;
  logic [NUM_LATCH-1:0] lat_set, lat_clr, lat_stat;
  logic                 gen_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_sel_q <= SRC_NONE;
      gen_en_q  <= 1'b0;
      acq_en_q  <= 1'b0;
    end else if (wr_en_i) begin
      gen_sel_q <= gen_src_e'(wr_data_i[CF_SEL_LSB +: SEL_W]);
      gen_en_q  <= wr_data_i[CF_GEN_EN];
      acq_en_q  <= wr_data_i[CF_ACQ_EN];
    end
  end

  always_comb begin
    ev_lvl            = '0;
    ev_lvl[EV_SCAN]   = scan_done_i;
    ev_lvl[EV_HALF]   = fifo_half_i;
    ev_lvl[EV_NEMPTY] = fifo_nempty_i;
    ev_lvl[EV_FULL]   = fifo_full_i;
    ev_lvl[EV_ACQ]    = acq_done_i;
  end

  irq_edge_det #(.N(NUM_EV)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ev_lvl),
    .rise_o (ev_rise)
  );

  irq_src_mux u_mux (
    .sel_i  (gen_sel_q),
    .rise_i (ev_rise),
    .set_o  (gen_set)
  );

  always_comb begin
    lat_set         = '0;
    lat_set[ST_ACQ] = ev_rise[EV_ACQ];
    lat_set[ST_GEN] = gen_set;
    lat_set[ST_OVF] = ev_rise[EV_FULL];
  end

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_lat
    assign lat_clr[i] = wr_en_i & wr_data_i[CF_CLR_LSB + i];
    irq_stat_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (lat_set[i]),
      .clr_i  (lat_clr[i]),
      .stat_o (lat_stat[i])
    );
  end

  assign rd_status_o = {fifo_nempty_i, lat_stat};
  assign irq_o = (lat_stat[ST_ACQ] & acq_en_q) | (lat_stat[ST_GEN] & gen_en_q);

  // without a write nothing can clear or disable, so the request holds
  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o);
  p_sel_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_sel_q == SRC_NONE && !lat_stat[ST_GEN] && !wr_en_i) |=> !lat_stat[ST_GEN]);
  p_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_o[ST_LIVE] == fifo_nempty_i);
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nempty = 0, half = 0, full = 0, scan = 0, acq = 0;
  logic       wr_en = 0;
  logic [6:0] wr_data = '0;
  logic [3:0] st;
  logic       irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_status_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_nempty_i(nempty), .fifo_half_i(half),
    .fifo_full_i(full), .scan_done_i(scan), .acq_done_i(acq),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_status_o(st), .irq_o(irq));

  function automatic logic [6:0] cw(input logic [1:0] sel, input logic ge, input logic ae,
                                    input logic ca, input logic cg, input logic co);
    return {co, cg, ca, ae, ge, sel};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", st, 4'h0);
    chk("R1 irq", irq, 1'b0);
    acq = 1; step(); acq = 0; step();
    chk("R1 acq enable off", irq, 1'b0);
    wr(cw(2'b00, 0, 0, 1, 0, 0));
  endtask

  task automatic t_select();
    wr(cw(2'b01, 1, 0, 0, 0, 0));
    scan = 1; step(); scan = 0;
    chk("R2 scan sets gen", st[1], 1'b1);
    chk("R3 irq on gen", irq, 1'b1);
    wr(cw(2'b01, 1, 0, 0, 1, 0));
    chk("R5 gen cleared", st[1], 1'b0);
    chk("R10 irq dropped", irq, 1'b0);
    wr(cw(2'b00, 1, 0, 0, 0, 0));
    scan = 1; half = 1; nempty = 1; step();
    scan = 0; half = 0; nempty = 0; step();
    chk("R2 select 00 none", st[1], 1'b0);
    wr(cw(2'b10, 1, 0, 0, 0, 0));
    half = 1; step();
    chk("R2 half sets gen", st[1], 1'b1);
    wr(cw(2'b10, 1, 0, 0, 1, 0));
    step(); step();
    chk("R11 held level no relatch", st[1], 1'b0);
    half = 0; step();
  endtask

  task automatic t_nempty();
    wr(cw(2'b11, 1, 0, 0, 0, 0));
    nempty = 1; #1;
    chk("R8 live follows high", st[3], 1'b1);
    @(negedge clk);
    chk("R2 nempty sets gen", st[1], 1'b1);
    nempty = 0; #1;
    chk("R8 live follows low", st[3], 1'b0);
    chk("R2 latched stays", st[1], 1'b1);
    @(negedge clk);
    wr(cw(2'b11, 0, 0, 0, 0, 0));
    chk("R3 gen disabled irq", irq, 1'b0);
    chk("R5 write0 keeps gen", st[1], 1'b1);
  endtask

  task automatic t_acq();
    acq = 1; step(); acq = 0;
    chk("R4 acq latched", st[0], 1'b1);
    chk("R4 acq disabled", irq, 1'b0);
    wr(cw(2'b11, 0, 1, 0, 0, 0));
    chk("R4 acq enabled", irq, 1'b1);
    wr(cw(2'b11, 1, 1, 0, 0, 0));
    wr(cw(2'b11, 1, 1, 1, 0, 0));
    chk("R10 gen still holds irq", irq, 1'b1);
    chk("R5 acq cleared", st[0], 1'b0);
    wr(cw(2'b11, 1, 1, 0, 1, 0));
    chk("R10 all clear irq low", irq, 1'b0);
    wr_en = 1; wr_data = cw(2'b11, 1, 1, 1, 0, 0); acq = 1;
    step(); wr_en = 0; wr_data = '0; acq = 0;
    chk("R9 set beats clear", st[0], 1'b1);
    wr(cw(2'b11, 1, 1, 1, 0, 0));
    acq = 1; step(); acq = 0; step();
    chk("R6 clear self-resets", st[0], 1'b1);
  endtask

  task automatic t_ovf();
    full = 1; step(); full = 0; step(); step();
    chk("R7 ovf sticky", st[2], 1'b1);
    wr(cw(2'b11, 1, 1, 0, 0, 0));
    chk("R5 write0 keeps ovf", st[2], 1'b1);
    wr(cw(2'b11, 1, 1, 0, 0, 1));
    chk("R7 ovf cleared", st[2], 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_nempty();
    t_acq();
    t_ovf();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule